// File: doc/BRIEF.md
# YCbCr to RGB565 Converter with Dither

This block is a streaming pixel processor. Each accepted sample carries an 8-bit luma value and two 8-bit colour-difference values. The colour-difference values are offset-binary, with 128 as zero. Luma is scaled by a contrast gain and shifted by a brightness offset. Both chroma components are scaled about their zero level by a saturation gain. All three results are then held inside the legal coding range of 1 to 254.

The limited values go through a fixed-point colour matrix to give 8-bit red, green and blue values. Each channel is then reduced to the 5-6-5 packing with error-feedback dither. The bits that truncation drops from a channel are added to the same channel of the next valid pixel on the line. A start-of-line flag clears that carried error.

The block has no back-pressure. The gain and offset controls are sampled together with each input pixel. Every valid input produces exactly one valid output four clocks later.

Top module: `ycc_rgb565`

## Requirements
- R1: Luma is computed as Y' = floor((Y*contrast + 32) / 64) + brightness - 128. A contrast code of 64 is unity gain and a brightness code of 128 is no shift.
- R2: Each chroma component C (Cb or Cr) is computed as C' = floor(((C-128)*saturation + 32) / 64) + 128. A saturation code of 0 gives exactly 128 on both components.
- R3: After R1 and R2, Y', Cb' and Cr' are each clamped to the range 1..254.
- R4: Red is computed as R = floor((Y'*1024 + 1404*(Cr'-128) + 512) / 1024), clamped to 0..255.
- R5: Green is computed as G = floor((Y'*1024 - 344*(Cb'-128) - 715*(Cr'-128) + 512) / 1024). Blue is computed as B = floor((Y'*1024 + 1774*(Cb'-128) + 512) / 1024). Both are clamped to 0..255.
- R6: When Cb' and Cr' are both 128, the red, green and blue values are all equal to Y'.
- R7: Dither works per channel as follows. S = min(value + carried error, 255). The output is the top bits of S: S>>3 for red and blue, S>>2 for green. The new carried error is the dropped low bits of S. The carried error changes only on valid pixels.
- R8: On a pixel with the start-of-line flag set, the carried error of every channel is taken as zero.
- R9: The output word puts red in bits [15:11], green in bits [10:5] and blue in bits [4:0].
- R10: out_valid_o equals in_valid_i delayed by exactly 4 clocks, and it is 0 during and just after reset. Idle cycles between pixels do not disturb the dither state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input pixel valid |
| in_sol_i | input | 1 | Input pixel is the first of a line |
| y_i | input | 8 | Luma sample |
| cb_i | input | 8 | Blue colour difference, offset 128 |
| cr_i | input | 8 | Red colour difference, offset 128 |
| contrast_i | input | 8 | Luma gain, 64 is unity |
| bright_i | input | 8 | Luma offset, 128 is neutral |
| sat_i | input | 8 | Chroma gain, 64 is unity |
| out_valid_o | output | 1 | Output word valid |
| rgb_o | output | 16 | Packed 5-6-5 pixel |

## Verification
Two things can act on the dither stage in the same cycle: a start-of-line reset of the carried error, and a saturating sum that would otherwise keep a full carry. The bench builds this case directly. It first feeds a run of pixels whose red channel is clipped at 255, so that a nonzero error is carried, and then raises the line-start flag on the next saturating pixel. Valid gaps are also placed just before line starts. Every output word is compared with a bench model that applies the clearing before the addition, so a design that adds first, or that lets an idle cycle alter the carry, gives a different word.

// File: rtl/ycc_pkg.sv
package ycc_pkg;
  localparam int GAIN_FRAC = 6;
  localparam int COEF_FRAC = 10;
  localparam int C_ZERO    = 128;
  localparam int LIM_LO    = 1;
  localparam int LIM_HI    = 254;
  // matrix coefficients scaled by 2^COEF_FRAC
  localparam int K_RV = 1404;
  localparam int K_GU = 344;
  localparam int K_GV = 715;
  localparam int K_BU = 1774;

  function automatic int clip_int(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/ycc_bcs.sv
module ycc_bcs
  import ycc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         sol_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] cb_i,
  input  logic [W-1:0] cr_i,
  input  logic [W-1:0] con_i,
  input  logic [W-1:0] bri_i,
  input  logic [W-1:0] sat_i,
  output logic         valid_o,
  output logic         sol_o,
  output logic [W-1:0] y_o,
  output logic [W-1:0] cb_o,
  output logic [W-1:0] cr_o
);
  localparam int HALF = 1 << (GAIN_FRAC - 1);

  int         y_lin;
  logic [W-1:0] y_lim;

  always_comb begin
    y_lin = ((int'(y_i) * int'(con_i) + HALF) >>> GAIN_FRAC) + int'(bri_i) - C_ZERO;
    y_lim = W'(clip_int(y_lin, LIM_LO, LIM_HI));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sol_o   <= 1'b0;
      y_o     <= '0;
    end else begin
      valid_o <= valid_i;
      sol_o   <= sol_i;
      y_o     <= y_lim;
    end
  end

  logic [W-1:0] c_in [2];
  assign c_in[0] = cb_i;
  assign c_in[1] = cr_i;

  for (genvar k = 0; k < 2; k++) begin : g_chroma
    int           c_lin;
    logic [W-1:0] c_lim;
    logic [W-1:0] c_q;
    always_comb begin
      c_lin = (((int'(c_in[k]) - C_ZERO) * int'(sat_i) + HALF) >>> GAIN_FRAC) + C_ZERO;
      c_lim = W'(clip_int(c_lin, LIM_LO, LIM_HI));
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) c_q <= W'(C_ZERO);
      else         c_q <= c_lim;
    end
  end

  assign cb_o = g_chroma[0].c_q;
  assign cr_o = g_chroma[1].c_q;

  // R3
  legal_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (y_o >= W'(LIM_LO) && y_o <= W'(LIM_HI) &&
                 cb_o >= W'(LIM_LO) && cb_o <= W'(LIM_HI) &&
                 cr_o >= W'(LIM_LO) && cr_o <= W'(LIM_HI)));

  // R2
  zero_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sat_i == '0) |=> (cb_o == W'(C_ZERO) && cr_o == W'(C_ZERO)));
endmodule

// File: rtl/ycc_matrix.sv
module ycc_matrix
  import ycc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         sol_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] cb_i,
  input  logic [W-1:0] cr_i,
  output logic         valid_o,
  output logic         sol_o,
  output logic [W-1:0] r_o,
  output logic [W-1:0] g_o,
  output logic [W-1:0] b_o
);
  localparam int A_W  = W + 4;
  localparam int RND  = 1 << (COEF_FRAC - 1);
  localparam int VMAX = (1 << W) - 1;

  int ys, u, v;
  int r_a, g_a, b_a;

  always_comb begin
    ys  = int'(y_i) <<< COEF_FRAC;
    u   = int'(cb_i) - C_ZERO;
    v   = int'(cr_i) - C_ZERO;
    r_a = (ys + K_RV * v + RND) >>> COEF_FRAC;
    g_a = (ys - K_GU * u - K_GV * v + RND) >>> COEF_FRAC;
    b_a = (ys + K_BU * u + RND) >>> COEF_FRAC;
  end

  // stage A: unclipped sums
  logic signed [A_W-1:0] r_s, g_s, b_s;
  logic                  valid_s, sol_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_s <= 1'b0;
      sol_s   <= 1'b0;
      r_s     <= '0;
      g_s     <= '0;
      b_s     <= '0;
    end else begin
      valid_s <= valid_i;
      sol_s   <= sol_i;
      r_s     <= A_W'(r_a);
      g_s     <= A_W'(g_a);
      b_s     <= A_W'(b_a);
    end
  end

  // stage B: clip to pixel range
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sol_o   <= 1'b0;
      r_o     <= '0;
      g_o     <= '0;
      b_o     <= '0;
    end else begin
      valid_o <= valid_s;
      sol_o   <= sol_s;
      r_o     <= W'(clip_int(int'(r_s), 0, VMAX));
      g_o     <= W'(clip_int(int'(g_s), 0, VMAX));
      b_o     <= W'(clip_int(int'(b_s), 0, VMAX));
    end
  end

  // R6
  grey_equal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cb_i == W'(C_ZERO) && cr_i == W'(C_ZERO)) |=> ##1
      (r_o == g_o && g_o == b_o));
endmodule

// File: rtl/ycc_dither.sv
module ycc_dither #(
  parameter int W  = 8,
  parameter int OW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          sol_i,
  input  logic [W-1:0]  v_i,
  output logic [OW-1:0] q_o
);
  localparam int SH = W - OW;

  logic [SH-1:0] err_q;
  logic [SH-1:0] err_use;
  logic [W:0]    sum;
  logic [W-1:0]  sat_v;

  always_comb begin
    err_use = sol_i ? '0 : err_q;
    sum     = {1'b0, v_i} + (W+1)'(err_use);
    sat_v   = sum[W] ? '1 : sum[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= '0;
      q_o   <= '0;
    end else if (valid_i) begin
      err_q <= sat_v[SH-1:0];
      q_o   <= sat_v[W-1:SH];
    end
  end

  // R8
  sol_no_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sol_i) |=> (q_o == $past(v_i[W-1:SH])));

  // R7
  full_scale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && v_i == '1) |=> (q_o == '1));
endmodule

// File: rtl/ycc_rgb565.sv
module ycc_rgb565 #(
  parameter int W   = 8,
  parameter int R_W = 5,
  parameter int G_W = 6,
  parameter int B_W = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic                 in_sol_i,
  input  logic [W-1:0]         y_i,
  input  logic [W-1:0]         cb_i,
  input  logic [W-1:0]         cr_i,
  input  logic [W-1:0]         contrast_i,
  input  logic [W-1:0]         bright_i,
  input  logic [W-1:0]         sat_i,
  output logic                 out_valid_o,
  output logic [R_W+G_W+B_W-1:0] rgb_o
);
  logic         b_valid, b_sol;
  logic [W-1:0] b_y, b_cb, b_cr;

  ycc_bcs #(.W(W)) u_bcs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .sol_i   (in_sol_i),
    .y_i     (y_i),
    .cb_i    (cb_i),
    .cr_i    (cr_i),
    .con_i   (contrast_i),
    .bri_i   (bright_i),
    .sat_i   (sat_i),
    .valid_o (b_valid),
    .sol_o   (b_sol),
    .y_o     (b_y),
    .cb_o    (b_cb),
    .cr_o    (b_cr)
  );

  logic         m_valid, m_sol;
  logic [W-1:0] ch8 [3];

  ycc_matrix #(.W(W)) u_matrix (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (b_valid),
    .sol_i   (b_sol),
    .y_i     (b_y),
    .cb_i    (b_cb),
    .cr_i    (b_cr),
    .valid_o (m_valid),
    .sol_o   (m_sol),
    .r_o     (ch8[0]),
    .g_o     (ch8[1]),
    .b_o     (ch8[2])
  );

  for (genvar c = 0; c < 3; c++) begin : g_dith
    localparam int OW = (c == 0) ? R_W : ((c == 1) ? G_W : B_W);
    logic [OW-1:0] q;
    ycc_dither #(.W(W), .OW(OW)) u_dith (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (m_valid),
      .sol_i   (m_sol),
      .v_i     (ch8[c]),
      .q_o     (q)
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_valid_o <= 1'b0;
    else         out_valid_o <= m_valid;
  end

  assign rgb_o = {g_dith[0].q, g_dith[1].q, g_dith[2].q};

  // edges since reset, for the latency window check
  logic [2:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  // R10
  valid_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 3'd4) |-> (out_valid_o == $past(in_valid_i, 4)));
endmodule

// File: tb/ycc_rgb565_test.sv
`timescale 1ns/1ps
module ycc_rgb565_test;
  localparam int MAXC = 8192;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sol = 1'b0;
  logic [7:0]  y = '0, cb = '0, cr = '0, con = '0, bri = '0, sat = '0;
  logic        out_valid;
  logic [15:0] rgb;

  always #10 clk = ~clk;

  ycc_rgb565 uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_sol_i(in_sol),
    .y_i(y), .cb_i(cb), .cr_i(cr), .contrast_i(con), .bright_i(bri), .sat_i(sat),
    .out_valid_o(out_valid), .rgb_o(rgb)
  );

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  bit          exp_v   [MAXC];
  logic [15:0] exp_rgb [MAXC];
  string       exp_tag [MAXC];
  int er = 0, eg = 0, eb = 0;

  function automatic int clip(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic logic [15:0] model(bit s, int yy, int u0, int v0, int c, int b, int g0);
    int y1, u1, v1, u, w, r8, g8, b8, sr, sg, sb;
    y1 = clip(((yy * c + 32) >>> 6) + b - 128, 1, 254);
    u1 = clip((((u0 - 128) * g0 + 32) >>> 6) + 128, 1, 254);
    v1 = clip((((v0 - 128) * g0 + 32) >>> 6) + 128, 1, 254);
    u = u1 - 128; w = v1 - 128;
    r8 = clip((y1 * 1024 + 1404 * w + 512) >>> 10, 0, 255);
    g8 = clip((y1 * 1024 - 344 * u - 715 * w + 512) >>> 10, 0, 255);
    b8 = clip((y1 * 1024 + 1774 * u + 512) >>> 10, 0, 255);
    if (s) begin er = 0; eg = 0; eb = 0; end
    sr = clip(r8 + er, 0, 255); er = sr & 7;
    sg = clip(g8 + eg, 0, 255); eg = sg & 3;
    sb = clip(b8 + eb, 0, 255); eb = sb & 7;
    return 16'(((sr >> 3) << 11) | ((sg >> 2) << 5) | (sb >> 3));
  endfunction

  task automatic check_at(int idx);
    bit ev;
    string t;
    ev = (idx >= 0) ? exp_v[idx] : 1'b0;
    t  = (idx >= 0) ? exp_tag[idx] : "R10";
    total++;
    if (out_valid !== ev || (ev && rgb !== exp_rgb[idx])) begin
      bad++;
      $display("FAIL %s: valid=%0b rgb=%h expected valid=%0b rgb=%h",
               t, out_valid, rgb, ev, ev ? exp_rgb[idx] : 16'h0);
    end
  endtask

  task automatic step(bit v, bit s, int yy, int u0, int v0, int c, int b, int g0, string tag);
    @(negedge clk);
    check_at(cyc - 4);
    in_valid = v; in_sol = s;
    y = 8'(yy); cb = 8'(u0); cr = 8'(v0); con = 8'(c); bri = 8'(b); sat = 8'(g0);
    exp_v[cyc] = v;
    exp_tag[cyc] = tag;
    exp_rgb[cyc] = v ? model(s, yy, u0, v0, c, b, g0) : 16'h0;
    cyc++;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R10: reset state
    total++;
    if (out_valid !== 1'b0 || rgb !== 16'h0) begin
      bad++;
      $display("FAIL R10 reset: valid=%0b rgb=%h expected valid=0 rgb=0000", out_valid, rgb);
    end
    rst_n = 1'b1;

    // R6: grey ramp at unity controls; R3 at the ends
    for (int i = 0; i < 16; i++) step(1, i == 0, i * 17, 128, 128, 64, 128, 64, "R6");
    step(1, 0, 0, 128, 128, 64, 128, 64, "R3");
    step(1, 0, 255, 128, 128, 64, 128, 64, "R3");

    // R1: contrast and brightness sweep, neutral chroma
    for (int i = 0; i < 64; i++)
      step(1, 0, $urandom_range(255), 128, 128, $urandom_range(255), $urandom_range(255), 64, "R1");

    // R2: saturation sweep, including zero gain
    for (int i = 0; i < 64; i++)
      step(1, 0, 120, $urandom_range(255), $urandom_range(255), 64, 128,
           (i % 8 == 0) ? 0 : $urandom_range(255), "R2");

    // R3: driven into both limits
    step(1, 1, 255, 255, 255, 255, 255, 255, "R3");
    step(1, 0, 0, 0, 0, 255, 0, 255, "R3");
    step(1, 0, 255, 0, 255, 255, 255, 255, "R3");
    step(1, 0, 10, 255, 0, 64, 0, 200, "R3");

    // R4 / R5: matrix under random chroma
    for (int i = 0; i < 48; i++)
      step(1, 0, $urandom_range(255), 128, $urandom_range(255), 64, 128, 64, "R4");
    for (int i = 0; i < 48; i++)
      step(1, 0, $urandom_range(255), $urandom_range(255), $urandom_range(255), 64, 128, 64, "R5");

    // R7: constant mid level accumulates error
    for (int i = 0; i < 12; i++) step(1, i == 0, 101, 128, 128, 64, 128, 64, "R7");
    for (int i = 0; i < 6; i++)  step(1, 0, 254, 128, 254, 64, 130, 64, "R7");

    // R8: line start on a saturating pixel carrying error, plus gaps before starts
    for (int i = 0; i < 5; i++) step(1, 0, 250, 128, 250, 64, 132, 64, "R8");
    step(1, 1, 250, 128, 250, 64, 132, 64, "R8");
    step(1, 0, 99, 128, 128, 64, 128, 64, "R8");
    step(0, 0, 7, 7, 7, 64, 128, 64, "R8");
    step(1, 1, 99, 128, 128, 64, 128, 64, "R8");
    for (int i = 0; i < 30; i++)
      step(1, (i % 5) == 0, $urandom_range(255), $urandom_range(255), $urandom_range(255), 64, 128, 64, "R8");

    // R10: random gaps must not disturb carried error
    for (int i = 0; i < 200; i++)
      step($urandom_range(1), (i % 37) == 0, $urandom_range(255), $urandom_range(255),
           $urandom_range(255), $urandom_range(255), $urandom_range(255), $urandom_range(255), "R10");

    // R9: long random stream, full packed word compare
    for (int i = 0; i < 2000; i++)
      step(($urandom_range(7) != 0), (i % 64) == 0, $urandom_range(255), $urandom_range(255),
           $urandom_range(255), $urandom_range(40, 110), $urandom_range(90, 170),
           $urandom_range(120), "R9");

    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "R10");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule